// File: doc/BRIEF.md
# Monitor Overflow Interrupt Combiner

This block gathers the overflow requests raised by a set of performance sub-monitors and turns them into one interrupt line. The sub-monitors fall into four classes: memory-controller units, memory-controller bridges, L3 cache slices and I/O bridges. Each class may have several instances. Every instance drives a level request that stays high until software clears the overflow inside that instance. The combiner folds the requests of each class into one status bit.

Software reads the class status through a small 32-bit register port and decides which class to service. A mask register, where a 1 blocks a source, selects which classes may raise the interrupt. The mask comes out of reset fully set, so the line stays quiet until software opens it. Writing 0xFFFFFFF0 opens the four defined classes and keeps the unused upper bits blocked.

Top module: `pmu_irq_combiner`

## Requirements
- R1: Status bit c is the OR of the requests of every instance of class c. Instance i of class c is input bit `c*INST_PER_CLASS + i`. The classes sit at fixed bits: memory-controller unit at bit 0, memory-controller bridge at bit 1, L3 cache at bit 2, I/O bridge at bit 3.
- R2: A status read returns zero in bits 31:4. Writes to the status address (0x000) change neither the status nor the mask.
- R3: After reset the mask reads 0xFFFFFFFF, and `irq_o` stays low whatever the requests until software clears a mask bit.
- R4: A write to the mask address (0x004) stores all 32 data bits, and a later mask read returns them. The mask changes only on such a write.
- R5: `irq_o` in the cycle after a clock edge equals the OR over bits 3:0 of (status AND NOT mask), taking both values as they were just before that edge.
- R6: A mask bit of 1 suppresses its class. With all four low mask bits set, `irq_o` stays low. Writing 0xFFFFFFF0 lets any of the four classes raise it.
- R7: Read data is registered. It is valid in the cycle after `reg_rd_en_i` and holds while no read is issued. A read issued in the same cycle as a mask write returns the mask value from before that write.
- R8: Addresses other than 0x000 and 0x004 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 4*INST_PER_CLASS | Level overflow requests, grouped by class |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Two things can happen in the same cycle: a mask write can coincide with a change in the requests, and a mask read can coincide with a mask write. The bench provokes the first by raising a request while all classes are masked and, in that same cycle, writing 0xFFFFFFF0. It then expects `irq_o` to stay low after that edge and to rise one edge later, because the interrupt flop still sees the old mask at the write edge. The bench provokes the second by issuing a read and a write to the mask address together. It expects the read to return the old mask and a following read to return the new one.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;
  // Number of monitor classes; bit positions in the status word are fixed.
  localparam int unsigned NUM_CLASS = 4;

  typedef enum int unsigned {
    CLS_MEM_CTRL   = 0,
    CLS_MEM_BRIDGE = 1,
    CLS_L3_CACHE   = 2,
    CLS_IO_BRIDGE  = 3
  } mon_class_e;

  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned DEF_DATA_W = 32;

  localparam logic [DEF_ADDR_W-1:0] ADDR_STATUS = 12'h000;
  localparam logic [DEF_ADDR_W-1:0] ADDR_MASK   = 12'h004;
endpackage

// File: rtl/pmu_class_reduce.sv
module pmu_class_reduce #(
  parameter int unsigned NUM_CLASS      = 4,
  parameter int unsigned INST_PER_CLASS = 2,
  localparam int unsigned SRC_W         = NUM_CLASS * INST_PER_CLASS
) (
  input  logic [SRC_W-1:0]     src_i,
  output logic [NUM_CLASS-1:0] status_o
);
  // One OR tree per class over its instance slice.
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    assign status_o[c] = |src_i[c*INST_PER_CLASS +: INST_PER_CLASS];
  end
endmodule

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MASK_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  logic hit;
  assign hit = wr_en_i && (addr_i == MASK_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '1;
    end else if (hit) begin
      mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/pmu_irq_flop.sv
module pmu_irq_flop #(
  parameter int unsigned NUM_CLASS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CLASS-1:0] status_i,
  input  logic [NUM_CLASS-1:0] mask_i,
  output logic                 irq_o
);
  logic pending;
  assign pending = |(status_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= pending;
    end
  end
endmodule

// File: rtl/pmu_read_mux.sv
module pmu_read_mux #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_CLASS = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = '0,
  localparam int unsigned PAD_W    = DATA_W - NUM_CLASS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_CLASS-1:0] status_i,
  input  logic [DATA_W-1:0]    mask_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    if (addr_i == STATUS_ADDR) begin
      sel = {{PAD_W{1'b0}}, status_i};
    end else if (addr_i == MASK_ADDR) begin
      sel = mask_i;
    end else begin
      sel = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      rdata_o <= sel;
    end
  end
endmodule

// File: rtl/pmu_irq_combiner.sv
module pmu_irq_combiner
  import pmu_irq_pkg::*;
#(
  parameter int unsigned INST_PER_CLASS = 2,
  parameter int unsigned DATA_W         = DEF_DATA_W,
  parameter int unsigned ADDR_W         = DEF_ADDR_W,
  localparam int unsigned SRC_W         = NUM_CLASS * INST_PER_CLASS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_req_i,
  input  logic              reg_wr_en_i,
  input  logic              reg_rd_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADDR_MASK);

  logic [NUM_CLASS-1:0] class_status;
  logic [DATA_W-1:0]    mask_q;

  pmu_class_reduce #(
    .NUM_CLASS     (NUM_CLASS),
    .INST_PER_CLASS(INST_PER_CLASS)
  ) u_reduce (
    .src_i   (src_req_i),
    .status_o(class_status)
  );

  pmu_mask_reg #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MASK_ADDR(A_MASK)
  ) u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en_i(reg_wr_en_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .mask_o (mask_q)
  );

  pmu_irq_flop #(
    .NUM_CLASS(NUM_CLASS)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .status_i(class_status),
    .mask_i  (mask_q[NUM_CLASS-1:0]),
    .irq_o   (irq_o)
  );

  pmu_read_mux #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_CLASS  (NUM_CLASS),
    .STATUS_ADDR(A_STATUS),
    .MASK_ADDR  (A_MASK)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (reg_rd_en_i),
    .addr_i  (reg_addr_i),
    .status_i(class_status),
    .mask_i  (mask_q),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/pmu_irq_combiner_chk.sv
module pmu_irq_combiner_chk
  import pmu_irq_pkg::*;
#(
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [SRC_W-1:0]     src_req_i,
  input logic                 reg_wr_en_i,
  input logic                 reg_rd_en_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic                 irq_o,
  input logic [NUM_CLASS-1:0] class_status,
  input logic [DATA_W-1:0]    mask_q
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADDR_MASK);

  // R3: leaving reset, mask fully set and line quiet
  p_quiet_after_rst_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_o && (&mask_q)));

  // R1: no request anywhere means no status bit
  p_no_src_no_status_r1: assert property (@(posedge clk) disable iff (rst)
    (src_req_i == '0) |-> (class_status == '0));

  // R2: upper status bits read as zero
  p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd_en_i && (reg_addr_i == A_STATUS)) |-> (reg_rdata_o[DATA_W-1:NUM_CLASS] == '0));

  // R4: mask moves only on a mask write
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr_en_i && (reg_addr_i == A_MASK)) |-> $stable(mask_q));

  // R6: all four classes masked keeps the line low
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(&mask_q[NUM_CLASS-1:0]) |-> !irq_o);

  // R5: line follows unmasked status one edge later
  p_irq_tracks_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(class_status & ~mask_q[NUM_CLASS-1:0])));

  // R7: read data holds while no read is issued
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd_en_i) |-> $stable(reg_rdata_o));
endmodule

bind pmu_irq_combiner pmu_irq_combiner_chk #(
  .SRC_W (SRC_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_req_i   (src_req_i),
  .reg_wr_en_i (reg_wr_en_i),
  .reg_rd_en_i (reg_rd_en_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .class_status(class_status),
  .mask_q      (mask_q)
);

// File: tb/test_pmu_irq_combiner.sv
module test_pmu_irq_combiner;
  localparam int unsigned INST  = 2;
  localparam int unsigned SRC_W = 4 * INST;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [SRC_W-1:0] src = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pmu_irq_combiner #(.INST_PER_CLASS(INST)) i_pmu_irq_combiner (
    .clk        (clk),
    .rst        (rst),
    .src_req_i  (src),
    .reg_wr_en_i(wr_en),
    .reg_rd_en_i(rd_en),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_status(input logic [SRC_W-1:0] s);
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = (s[c*INST +: INST] != '0);
    return r;
  endfunction

  // Inputs change 1 ns after a rising edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    check("R3 irq after reset", {31'd0, irq}, 32'd0);
    rd(12'h004, v);
    check("R3 mask reset value", v, 32'hFFFF_FFFF);

    // R3: every request high while fully masked
    src = '1;
    repeat (3) @(posedge clk); #1;
    check("R3 masked requests stay quiet", {31'd0, irq}, 32'd0);

    // R2 / R1: status read with all requests
    rd(12'h000, v);
    check("R2 status upper zero, R1 all classes", v, 32'h0000_000F);
    wr(12'h000, 32'h0000_0000);
    rd(12'h004, v);
    check("R2 status write leaves mask", v, 32'hFFFF_FFFF);
    rd(12'h000, v);
    check("R2 status write ignored", v, 32'h0000_000F);

    // R8: unmapped address
    wr(12'h008, 32'h0000_0000);
    rd(12'h004, v);
    check("R8 unmapped write ignored", v, 32'hFFFF_FFFF);
    rd(12'h008, v);
    check("R8 unmapped read zero", v, 32'h0);

    // R7: read data holds without a read
    rd(12'h004, v);
    repeat (3) @(posedge clk); #1;
    check("R7 read data holds", rdata, 32'hFFFF_FFFF);

    // R4: arbitrary pattern stored in full
    wr(12'h004, 32'hA5C3_0F5A);
    rd(12'h004, v);
    check("R4 mask readback", v, 32'hA5C3_0F5A);

    // Same-cycle mask write and request change (R5, R6)
    src = '0;
    wr(12'h004, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    src = 8'b0000_0100;           // bridge class instance 0
    wr_en = 1'b1; addr = 12'h004; wdata = 32'hFFFF_FFF0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R5 old mask used at write edge", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    check("R6 unmask FFFFFFF0 raises line", {31'd0, irq}, 32'd1);

    // R7: same-cycle read and write of the mask
    rd_en = 1'b1; wr_en = 1'b1; addr = 12'h004; wdata = 32'h1234_5678;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
    check("R7 read during write returns old", rdata, 32'hFFFF_FFF0);
    rd(12'h004, v);
    check("R7 following read returns new", v, 32'h1234_5678);

    // Exhaustive sweep: every low mask nibble against every request pattern
    for (int m = 0; m < 16; m++) begin
      wr(12'h004, {28'hFFF_FFFF, 4'(m)});
      rd(12'h004, v);
      check("R4 sweep mask readback", v, {28'hFFF_FFFF, 4'(m)});
      for (int s = 0; s < (1 << SRC_W); s++) begin
        src = SRC_W'(s);
        @(posedge clk); #1;
        check("R5 R6 irq vs status and mask", {31'd0, irq},
              {31'd0, |(exp_status(SRC_W'(s)) & ~4'(m))});
        if ((s % 17) == 0) begin
          rd(12'h000, v);
          check("R1 R2 status pattern", v, {28'd0, exp_status(SRC_W'(s))});
        end
      end
    end

    // R1: each single instance maps to its class bit
    for (int b = 0; b < SRC_W; b++) begin
      src = SRC_W'(1) << b;
      rd(12'h000, v);
      check("R1 instance to class bit", v, 32'd1 << (b / INST));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule